// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the clocked control front end of a synchronous burst SRAM, built around a small on-chip byte-lane array for test. On every rising clock edge it classifies the cycle from the inputs:

- power-down
- deselect
- burst start
- burst continue
- burst suspend
- idle

It then picks the word address for that cycle. A start takes the external address. A continue takes the next address in the burst. A suspend keeps the current address. It also decides whether the cycle writes the array or reads it.

Two strobes can open a burst. The processor-side strobe always opens a read, so any write in that burst comes on a later clock. The controller-side strobe opens a read or a write depending on the write inputs.

Read data comes out of a two-stage pipeline. The bus direction is decided combinationally from an output enable that is never sampled by the clock. That enable is overridden while a write cycle is in progress and while the device sleeps.

Top module: `burst_sram_ctrl`

## Requirements
- R1: After reset, `data_drive` is 0 and `data_out` is all zeros.
- R2: Write request and byte lanes follow these rules. A cycle requests a write when `wr_all_n` is 0; this writes all byte lanes. It also requests a write when `wr_byte_en_n` is 0 and at least one bit of `byte_sel_n` is 0; this writes only the lanes whose `byte_sel_n` bit is 0, with bit i covering `data_in[8i+7:8i]`. With `wr_all_n`, `wr_byte_en_n` and every `byte_sel_n` bit at 1, nothing is written.
- R3: A burst start on `strobe_cpu_n` low is always a read, whatever the write inputs are.
- R4: A burst start on `strobe_ctl_n` low, with `strobe_cpu_n` high and a write requested, writes `data_in` at `addr_in`.
- R5: A continue cycle has both strobes high, a burst open and `advance_n` low. It uses the current address plus one in the two low bits, wrapping within the aligned four-word group. The upper bits are unchanged.
- R6: A suspend cycle has both strobes high, a burst open and `advance_n` high. It reuses the current address, for a read or a write.
- R7: The read address is registered at the command edge. Read data is registered at the following edge, and at that edge it becomes valid on `data_out`.
- R8: `data_drive` follows `out_en_n` combinationally, with no clock edge needed. Valid read data plus `out_en_n` low gives `data_drive` 1. `out_en_n` high gives 0.
- R9: While the present inputs make the cycle a write, `data_drive` is 0 even if read data is valid and `out_en_n` is low.
- R10: A cycle with either strobe low while any chip enable is inactive is a deselect. It closes the burst, so later continue or suspend cycles neither read nor write, and `data_drive` returns to 0 once the pipeline drains. All enables are active when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0.
- R11: While `sleep` is 1, all other inputs are ignored, `data_drive` is 0, and the array, burst address and read pipeline are held.
- R12: After a burst opened by the processor-side strobe, a continue or suspend cycle with a write requested writes the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_a_n | input | 1 | Chip enable A, active low |
| cs_b | input | 1 | Chip enable B, active high |
| cs_c_n | input | 1 | Chip enable C, active low |
| strobe_cpu_n | input | 1 | Processor-side burst start strobe (always a read), active low |
| strobe_ctl_n | input | 1 | Controller-side burst start strobe, active low |
| advance_n | input | 1 | Advance burst address when low |
| wr_all_n | input | 1 | Global write of all bytes, active low |
| wr_byte_en_n | input | 1 | Enables per-byte writes, active low |
| byte_sel_n | input | NB | Per-byte write selects, active low |
| sleep | input | 1 | Power-down, active high |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr_in | input | AW | External word address |
| data_in | input | NB*BW | Write data |
| data_out | output | NB*BW | Registered read data |
| data_drive | output | 1 | Data bus drive enable (1 = drive, 0 = tri-state) |

## Verification
The bench uses the defaults: AW=8, NB=4 and BW=8. This gives a 256-word array that the bench fills entirely through four-word write bursts before any read. From then on, every random read has a known expected value.

Four byte lanes are enough to mix partial and full writes in one word. They also allow the all-selects-high no-write case to be read back.

Eight address bits put many four-word groups side by side. A wrap that wrongly carries into the upper bits therefore reads a neighbouring group's distinct data, and the compare catches it.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  localparam int GROUP_BITS = 2;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_SLEEP = 3'd1,
    CYC_DESEL = 3'd2,
    CYC_START = 3'd3,
    CYC_CONT  = 3'd4,
    CYC_SUSP  = 3'd5
  } cyc_kind_e;

  typedef enum logic [1:0] {
    SRC_EXTERNAL = 2'd0,
    SRC_NEXT     = 2'd1,
    SRC_CURRENT  = 2'd2
  } addr_src_e;

endpackage

// File: rtl/burst_cycle_decode.sv
module burst_cycle_decode
  import burst_sram_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic                 cs_a_n,
  input  logic                 cs_b,
  input  logic                 cs_c_n,
  input  logic                 strobe_cpu_n,
  input  logic                 strobe_ctl_n,
  input  logic                 advance_n,
  input  logic                 wr_all_n,
  input  logic                 wr_byte_en_n,
  input  logic [NB-1:0]        byte_sel_n,
  input  logic                 sleep,
  input  logic                 burst_active,
  output cyc_kind_e            cyc_kind,
  output addr_src_e            addr_src,
  output logic                 cyc_write,
  output logic                 cyc_read,
  output logic [NB-1:0]        byte_we
);

  // Write request from the raw write inputs
  function automatic logic write_request(input logic all_n, input logic ben_n,
                                         input logic [NB-1:0] sel_n);
    return (!all_n) || (!ben_n && !(&sel_n));
  endfunction

  // Lanes that a write would touch
  function automatic logic [NB-1:0] lane_mask(input logic all_n, input logic ben_n,
                                              input logic [NB-1:0] sel_n);
    if (!all_n)      return {NB{1'b1}};
    else if (!ben_n) return ~sel_n;
    else             return '0;
  endfunction

  logic chips_on;
  logic start_req;
  logic wr_req;

  assign chips_on  = !cs_a_n && cs_b && !cs_c_n;
  assign start_req = !strobe_cpu_n || !strobe_ctl_n;
  assign wr_req    = write_request(wr_all_n, wr_byte_en_n, byte_sel_n);

  always_comb begin
    cyc_kind  = CYC_IDLE;
    addr_src  = SRC_CURRENT;
    cyc_write = 1'b0;
    if (sleep) begin
      cyc_kind = CYC_SLEEP;
    end else if (start_req) begin
      if (!chips_on) begin
        cyc_kind = CYC_DESEL;
      end else begin
        cyc_kind  = CYC_START;
        addr_src  = SRC_EXTERNAL;
        // processor-side strobe wins and forces a read
        cyc_write = strobe_cpu_n && wr_req;
      end
    end else if (burst_active) begin
      if (!advance_n) begin
        cyc_kind = CYC_CONT;
        addr_src = SRC_NEXT;
      end else begin
        cyc_kind = CYC_SUSP;
      end
      cyc_write = wr_req;
    end
  end

  assign cyc_read = ((cyc_kind == CYC_START) || (cyc_kind == CYC_CONT) ||
                     (cyc_kind == CYC_SUSP)) && !cyc_write;

  assign byte_we = cyc_write ? lane_mask(wr_all_n, wr_byte_en_n, byte_sel_n) : '0;

endmodule

// File: rtl/burst_addr_unit.sv
module burst_addr_unit
  import burst_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_kind_e     cyc_kind,
  input  addr_src_e     addr_src,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] sel_addr,
  output logic [AW-1:0] burst_addr,
  output logic          burst_active
);

  localparam int UPPER_W = AW - GROUP_BITS;

  // Linear wrap inside an aligned group of 2**GROUP_BITS words
  function automatic logic [AW-1:0] group_next(input logic [AW-1:0] a);
    logic [GROUP_BITS-1:0] low;
    low = a[GROUP_BITS-1:0] + GROUP_BITS'(1);
    return {a[AW-1:GROUP_BITS], low};
  endfunction

  logic [AW-1:0] addr_q;
  logic          active_q;
  logic [UPPER_W-1:0] upper_unused;

  assign upper_unused = addr_q[AW-1:GROUP_BITS];

  always_comb begin
    unique case (addr_src)
      SRC_EXTERNAL: sel_addr = addr_in;
      SRC_NEXT:     sel_addr = group_next(addr_q);
      default:      sel_addr = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      active_q <= 1'b0;
    end else begin
      case (cyc_kind)
        CYC_START: begin
          addr_q   <= sel_addr;
          active_q <= 1'b1;
        end
        CYC_CONT:  addr_q   <= sel_addr;
        CYC_DESEL: active_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign burst_addr   = addr_q;
  assign burst_active = active_q;

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    lane_we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB*BW-1:0] wdata,
  input  logic             rd_en,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane_mem [DEPTH];
    logic [BW-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (lane_we[b]) lane_mem[waddr] <= wdata[b*BW +: BW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lane_q <= '0;
      else if (rd_en) lane_q <= lane_mem[raddr];
    end

    assign rdata[b*BW +: BW] = lane_q;
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             advance_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_en_n,
  input  logic [NB-1:0]    byte_sel_n,
  input  logic             sleep,
  input  logic             out_en_n,
  input  logic [AW-1:0]    addr_in,
  input  logic [NB*BW-1:0] data_in,
  output logic [NB*BW-1:0] data_out,
  output logic             data_drive
);

  localparam int DW = NB * BW;

  cyc_kind_e     cyc_kind;
  addr_src_e     addr_src;
  logic          cyc_write;
  logic          cyc_read;
  logic [NB-1:0] byte_we;
  logic [AW-1:0] sel_addr;
  logic [AW-1:0] burst_addr;
  logic          burst_active;

  logic          rd_pend_q;
  logic [AW-1:0] rd_addr_q;
  logic          out_valid_q;
  logic          arr_rd_en;
  logic [DW-1:0] arr_rdata;

  burst_cycle_decode #(.NB(NB)) u_decode (
    .cs_a_n       (cs_a_n),
    .cs_b         (cs_b),
    .cs_c_n       (cs_c_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .advance_n    (advance_n),
    .wr_all_n     (wr_all_n),
    .wr_byte_en_n (wr_byte_en_n),
    .byte_sel_n   (byte_sel_n),
    .sleep        (sleep),
    .burst_active (burst_active),
    .cyc_kind     (cyc_kind),
    .addr_src     (addr_src),
    .cyc_write    (cyc_write),
    .cyc_read     (cyc_read),
    .byte_we      (byte_we)
  );

  burst_addr_unit #(.AW(AW)) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_kind     (cyc_kind),
    .addr_src     (addr_src),
    .addr_in      (addr_in),
    .sel_addr     (sel_addr),
    .burst_addr   (burst_addr),
    .burst_active (burst_active)
  );

  // Read pipeline: address stage, then data stage; frozen while sleeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q   <= 1'b0;
      rd_addr_q   <= '0;
      out_valid_q <= 1'b0;
    end else if (cyc_kind != CYC_SLEEP) begin
      rd_pend_q   <= cyc_read;
      rd_addr_q   <= sel_addr;
      out_valid_q <= rd_pend_q;
    end
  end

  assign arr_rd_en = rd_pend_q && !sleep;

  sram_byte_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .lane_we (byte_we),
    .waddr   (sel_addr),
    .wdata   (data_in),
    .rd_en   (arr_rd_en),
    .raddr   (rd_addr_q),
    .rdata   (arr_rdata)
  );

  assign data_out   = arr_rdata;
  // output enable is combinational; a write cycle or sleep overrides it
  assign data_drive = out_valid_q && !out_en_n && !sleep && !cyc_write;

endmodule

// File: rtl/burst_sram_ctrl_chk.sv
module burst_sram_ctrl_chk
  import burst_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep,
  input logic          strobe_cpu_n,
  input logic          out_en_n,
  input logic          data_drive,
  input cyc_kind_e     cyc_kind,
  input logic          cyc_write,
  input logic [AW-1:0] burst_addr,
  input logic          burst_active,
  input logic          rd_pend_q,
  input logic          out_valid_q
);

  // R9
  write_masks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_write |-> !data_drive);

  // R11
  sleep_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !data_drive);

  // R11
  sleep_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(burst_addr) && $stable(burst_active));

  // R3
  cpu_start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_START && !strobe_cpu_n) |-> !cyc_write);

  // R5
  group_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_CONT) |=>
      (burst_addr[1:0] == 2'($past(burst_addr[1:0]) + 2'd1)) &&
      (burst_addr[AW-1:2] == $past(burst_addr[AW-1:2])));

  // R6
  suspend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_SUSP) |=> $stable(burst_addr));

  // R10
  deselect_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == CYC_DESEL) |=> !burst_active);

  // R7
  read_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend_q && !sleep) |=> out_valid_q);

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !data_drive);

endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sleep        (sleep),
  .strobe_cpu_n (strobe_cpu_n),
  .out_en_n     (out_en_n),
  .data_drive   (data_drive),
  .cyc_kind     (cyc_kind),
  .cyc_write    (cyc_write),
  .burst_addr   (burst_addr),
  .burst_active (burst_active),
  .rd_pend_q    (rd_pend_q),
  .out_valid_q  (out_valid_q)
);

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctrl_bench;

  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 8;
  localparam int DW = NB * BW;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_a_n, cs_b, cs_c_n, cpu_n, ctl_n, adv_n, gw_n, bwe_n, slp, oe_n;
  logic [NB-1:0] bsel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          drive;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  burst_sram_ctrl #(.AW(AW), .NB(NB), .BW(BW)) u_burst_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .strobe_cpu_n(cpu_n), .strobe_ctl_n(ctl_n), .advance_n(adv_n),
    .wr_all_n(gw_n), .wr_byte_en_n(bwe_n), .byte_sel_n(bsel_n), .sleep(slp),
    .out_en_n(oe_n), .addr_in(addr), .data_in(din), .data_out(dout),
    .data_drive(drive)
  );

  // ---------------- behavioural reference ----------------
  logic [DW-1:0] ref_mem [WORDS];
  bit            m_open;
  int            m_addr;
  bit            m_pend;
  int            m_paddr;
  bit            m_valid;
  logic [DW-1:0] m_data;

  function automatic logic [DW-1:0] fill_val(input int a);
    return {8'(a), 8'(~a), 8'(a ^ 8'h5A), 8'(8'hC3 + a)};
  endfunction

  // kind: 0 idle, 1 sleep, 2 deselect, 3 start, 4 continue, 5 suspend
  task automatic classify(output int kind, output bit wr);
    bit wants;
    wants = (gw_n == 1'b0) || (bwe_n == 1'b0 && bsel_n != '1);
    wr = 0;
    if (slp) kind = 1;
    else if (!cpu_n || !ctl_n) begin
      if (cs_a_n == 1'b0 && cs_b == 1'b1 && cs_c_n == 1'b0) begin
        kind = 3;
        wr = (cpu_n == 1'b1) && wants;
      end else kind = 2;
    end else if (!m_open) kind = 0;
    else begin
      kind = adv_n ? 5 : 4;
      wr = wants;
    end
  endtask

  task automatic model_edge();
    int kind; bit wr; int a;
    logic [DW-1:0] nd; bit nv;
    classify(kind, wr);
    if (kind == 1) return;
    nd = m_pend ? ref_mem[m_paddr] : m_data;
    nv = m_pend;
    if (kind == 3) a = addr;
    else if (kind == 4) a = (m_addr & ~3) | ((m_addr + 1) & 3);
    else a = m_addr;
    if (kind == 3) m_open = 1;
    if (kind == 2) m_open = 0;
    if (kind >= 3) m_addr = a;
    if (wr) begin
      for (int b = 0; b < NB; b++)
        if (gw_n == 1'b0 || bsel_n[b] == 1'b0)
          ref_mem[a][b*BW +: BW] = din[b*BW +: BW];
    end
    m_pend  = (kind >= 3) && !wr;
    m_paddr = a;
    m_data  = nd;
    m_valid = nv;
  endtask

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs already applied at a falling edge
  task automatic step(input string tag);
    int kind; bit wr; bit exp_drive;
    #1;
    classify(kind, wr);
    exp_drive = m_valid && !oe_n && !slp && !wr;
    chk({tag, " drive"}, {31'd0, drive}, {31'd0, exp_drive});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (m_valid) chk({tag, " data"}, dout, m_data);
  endtask

  task automatic quiet();
    cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    cpu_n = 1; ctl_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bsel_n = '1;
    slp = 0; oe_n = 0; addr = '0; din = '0;
  endtask

  task automatic start_cpu(input int a);
    quiet(); cpu_n = 0; gw_n = 0; addr = AW'(a);
  endtask

  task automatic cont_read();
    quiet(); adv_n = 0;
  endtask

  // ---------------- stimulus ----------------
  logic [DW-1:0] exp_w;

  initial begin
    quiet();
    for (int i = 0; i < WORDS; i++) ref_mem[i] = 'x;
    m_open = 0; m_addr = 0; m_pend = 0; m_paddr = 0; m_valid = 0; m_data = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset drive", {31'd0, drive}, 32'd0);
    chk("R1 reset data", dout, '0);

    // Fill every word with controller-side write bursts (R4, R5)
    for (int g = 0; g < WORDS / 4; g++) begin
      quiet(); ctl_n = 0; gw_n = 0; addr = AW'(g * 4); din = fill_val(g * 4);
      step("R4 fill start");
      for (int k = 1; k < 4; k++) begin
        quiet(); adv_n = 0; gw_n = 0; din = fill_val(g * 4 + k);
        step("R5 fill cont");
      end
    end

    // R3: processor strobe with global write low still reads
    start_cpu(8'h12); step("R3 start");
    chk("R7 no data yet", {31'd0, drive}, 32'd0);
    cont_read(); step("R5 cont 13");
    chk("R7 data after one more edge", dout, fill_val(8'h12));
    cont_read(); step("R5 cont wrap 10");
    cont_read(); step("R5 cont 11");
    chk("R5 wrapped word", dout, fill_val(8'h10));
    quiet(); step("R6 suspend");
    quiet(); step("R6 suspend");
    chk("R6 held word", dout, fill_val(8'h11));
    quiet(); step("R6 suspend");
    chk("R6 held word again", dout, fill_val(8'h11));

    // R8: asynchronous output enable within one cycle
    quiet(); oe_n = 1; #1;
    chk("R8 oe high", {31'd0, drive}, 32'd0);
    oe_n = 0; #1;
    chk("R8 oe low", {31'd0, drive}, 32'd1);
    step("R8 cycle");

    // R9: write cycle masks drive while read data is valid
    quiet(); gw_n = 0; din = fill_val(8'h11); #1;
    chk("R9 masked", {31'd0, drive}, 32'd0);
    step("R9 cycle");

    // R12 and R2: byte write after processor-side start
    start_cpu(8'h40); step("R12 start");
    quiet(); adv_n = 0; bwe_n = 0; bsel_n = 4'b1010; din = 32'hAABBCCDD;
    step("R12 byte write");
    quiet(); adv_n = 0; bwe_n = 0; bsel_n = 4'b1111; din = 32'h11111111;
    step("R2 no lanes");
    exp_w = fill_val(8'h41);
    exp_w[23:16] = 8'hBB;
    exp_w[7:0]   = 8'hDD;
    start_cpu(8'h41); step("R12 readback");
    cont_read(); step("R12 readback");
    chk("R12 merged bytes", dout, exp_w);
    cont_read(); step("R2 readback");
    chk("R2 untouched word", dout, fill_val(8'h42));

    // R10: deselect closes the burst; later cycles do nothing
    start_cpu(8'h20); cs_b = 0; step("R10 deselect");
    quiet(); adv_n = 0; gw_n = 0; din = 32'hDEADBEEF; step("R10 dead cont");
    quiet(); adv_n = 0; step("R10 dead cont");
    quiet(); step("R10 dead suspend");
    chk("R10 drive off", {31'd0, drive}, 32'd0);
    start_cpu(8'h43); step("R10 check");
    cont_read(); step("R10 check");
    chk("R10 word not written", dout, fill_val(8'h43));
    cont_read(); step("R10 check");
    chk("R10 neighbour not written", dout, fill_val(8'h40));

    // R11: sleep ignores everything
    start_cpu(8'h30); step("R11 pre");
    cont_read(); step("R11 pre");
    quiet(); slp = 1; gw_n = 0; ctl_n = 0; addr = 8'h99; din = 32'h0; #1;
    chk("R11 drive off", {31'd0, drive}, 32'd0);
    step("R11 sleep");
    quiet(); slp = 1; adv_n = 0; gw_n = 0; step("R11 sleep");
    cont_read(); step("R11 resume");
    chk("R11 pipeline held", dout, fill_val(8'h31));
    cont_read(); step("R11 resume");
    chk("R11 address held", dout, fill_val(8'h32));

    // Random mix, compared every cycle against the reference
    for (int n = 0; n < 4000; n++) begin
      int r;
      quiet();
      r = int'($urandom_range(0, 99));
      slp    = ($urandom_range(0, 15) == 0);
      cs_b   = ($urandom_range(0, 9) != 0);
      cs_a_n = ($urandom_range(0, 19) == 0);
      cpu_n  = !(r < 12);
      ctl_n  = !(r >= 12 && r < 24);
      adv_n  = $urandom_range(0, 3) == 0;
      gw_n   = $urandom_range(0, 3) != 0;
      bwe_n  = $urandom_range(0, 2) != 0;
      bsel_n = NB'($urandom);
      oe_n   = $urandom_range(0, 4) == 0;
      addr   = AW'($urandom);
      din    = DW'($urandom);
      step("R2 R5 R6 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule